// File: doc/BRIEF.md
# Systolic Band Matrix-Vector Multiplier

This block forms y = A·x for an N×N band matrix whose nonzero entries lie within HALF_BW places of the main diagonal. The default is a tri-diagonal 8×8 matrix. The work is done by a linear chain of 2·HALF_BW+1 multiply-accumulate cells. Vector elements enter at the left end and move one cell to the right per clock. Partial sums of y enter at the right end as zeros and move one cell to the left per clock. A partial sum changes only in a cell where it meets a vector element. It picks up its band terms one by one on the way through, and it leaves the left end holding the finished dot product.

A run begins with a one-cycle start pulse. The first vector element x1 is presented in the same cycle as that pulse, and the remaining elements follow every second cycle. Time zero is the cycle after the start pulse, when x1 sits in the first cell's input register. The surrounding logic drives one signed coefficient per cell in every cycle, following the fixed schedule given below. Results leave the block in row order, each one with a valid flag. A done pulse is raised together with the last result.

Top module: `bandmv_top`

## Requirements
- R1: After reset, and before any start is accepted, y_valid_o and done_o are low.
- R2: Each result equals the signed sum over the band of a(i,j)·x_j, formed from DW-bit signed coefficients and vector elements.
- R3: Row i (1-based) appears on y_data_o with y_valid_o high in cycle 2·HALF_BW+1+2·(i-1) after time zero, rows in ascending order. y_valid_o is low in every other cycle and is never high in two consecutive cycles.
- R4: done_o is high for exactly one cycle, in cycle 2·(N-1)+2·HALF_BW+1 after time zero (17 for the defaults), together with the valid output of row N.
- R5: A start pulse that arrives while a run is in progress is ignored. The current run keeps its timing and its results, and no second run begins.
- R6: A coefficient presented to a cell in a cycle when no vector element is in that cell has no effect on any result. Vector data presented while x_valid_i is low has no effect on any result.
- R7: Products are kept at full precision. Accumulation wraps modulo 2^AW with no saturation.
- R8: Cell k (0-based, coefficient on coef_i[k*DW +: DW]) handles the diagonal j-i = HALF_BW-k. In cycle t after time zero, when t-k is even, it pairs row i = (t-2·HALF_BW+k)/2+1 with element j = (t-k)/2+1, and it must receive a(i,j) in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a run |
| x_valid_i | input | 1 | Marks x_data_i as a vector element |
| x_data_i | input | DW | Signed vector element |
| coef_i | input | (2·HALF_BW+1)·DW | Signed coefficient for each cell, cell k at bits k*DW upward |
| y_valid_o | output | 1 | Marks y_data_o as a finished row result |
| y_data_o | output | AW | Signed row result |
| done_o | output | 1 | High together with the last row result |

## Verification
The bench drives a mixed-sign matrix whose values differ per entry. Any exchange of diagonals, cells or rows therefore shows up as a wrong row value, and any skew in the schedule shows up as a missed or moved valid. A second matrix of mostly negative values checks that signed multiplication is handled correctly. A third matrix and vector built from the most negative DW-bit value check that products are kept at full width and that the sum wraps. Two further runs inject garbage on coefficient slots and x lanes that carry no valid pair, and extra start pulses in the middle of a run. These runs separate correct gating and start rejection from designs that simply accumulate whatever is present.

// File: rtl/bandmv_pkg.sv
package bandmv_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } bmv_phase_e;

    // Cycle of the last result, counted from time zero.
    function automatic int bmv_last_cycle(input int n, input int half_bw);
        return 2 * (n - 1) + 2 * half_bw + 1;
    endfunction

endpackage

// File: rtl/bandmv_cell.sv
module bandmv_cell #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 x_vld_i,
    input  logic signed [DW-1:0] x_dat_i,
    input  logic                 y_vld_i,
    input  logic signed [AW-1:0] y_dat_i,
    input  logic signed [DW-1:0] coef_i,
    output logic                 x_vld_o,
    output logic signed [DW-1:0] x_dat_o,
    output logic                 y_vld_o,
    output logic signed [AW-1:0] y_dat_o
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic                 xv;
        logic signed [DW-1:0] xd;
        logic                 yv;
        logic signed [AW-1:0] yd;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] term;

    always_comb begin
        prod = coef_i * x_dat_i;
        term = AW'(prod);
        st_d    = st_q;
        st_d.xv = x_vld_i;
        st_d.xd = x_vld_i ? x_dat_i : '0;
        st_d.yv = y_vld_i;
        if (!y_vld_i) begin
            st_d.yd = '0;
        end else if (x_vld_i) begin
            st_d.yd = y_dat_i + term;
        end else begin
            st_d.yd = y_dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_vld_o = st_q.xv;
    assign x_dat_o = st_q.xd;
    assign y_vld_o = st_q.yv;
    assign y_dat_o = st_q.yd;

endmodule

// File: rtl/bandmv_ctrl.sv
module bandmv_ctrl
    import bandmv_pkg::*;
#(
    parameter int N       = 8,
    parameter int HALF_BW = 1,
    parameter int LAST    = bmv_last_cycle(N, HALF_BW),
    parameter int CW      = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          inject_o,
    output logic          done_o,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] INJ_END  = CW'(2 * N);
    localparam logic [CW-1:0] CNT_STOP = CW'(LAST - 1);

    typedef struct packed {
        bmv_phase_e    ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_RUN;
                    st_d.cnt = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == CNT_STOP) begin
                    st_d.ph   = PH_IDLE;
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign inject_o = (st_q.ph == PH_RUN) && !st_q.cnt[0] && (st_q.cnt < INJ_END);
    assign done_o   = st_q.done;
    assign busy_o   = (st_q.ph == PH_RUN);
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/bandmv_top.sv
module bandmv_top
    import bandmv_pkg::*;
#(
    parameter int N       = 8,
    parameter int HALF_BW = 1,
    parameter int DW      = 16,
    parameter int AW      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        x_valid_i,
    input  logic signed [DW-1:0]        x_data_i,
    input  logic [(2*HALF_BW+1)*DW-1:0] coef_i,
    output logic                        y_valid_o,
    output logic signed [AW-1:0]        y_data_o,
    output logic                        done_o
);
    localparam int W    = 2 * HALF_BW + 1;
    localparam int LAST = bmv_last_cycle(N, HALF_BW);
    localparam int CW   = $clog2(LAST + 1);

    typedef struct packed {
        logic                 v;
        logic signed [DW-1:0] d;
    } xin_st_t;

    xin_st_t xin_d, xin_q;

    always_comb begin
        xin_d   = xin_q;
        xin_d.v = x_valid_i;
        xin_d.d = x_valid_i ? x_data_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xin_q <= '0;
        end else begin
            xin_q <= xin_d;
        end
    end

    logic          inject_w;
    logic          busy_w;
    logic [CW-1:0] cnt_w;

    bandmv_ctrl #(
        .N(N), .HALF_BW(HALF_BW), .LAST(LAST), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .inject_o(inject_w), .done_o(done_o), .busy_o(busy_w), .cnt_o(cnt_w)
    );

    // x chain: xv_w[k] feeds cell k; xo_* are cell outputs.
    logic                 xv_w [W];
    logic signed [DW-1:0] xd_w [W];
    logic                 xo_v [W];
    logic signed [DW-1:0] xo_d [W];
    // y chain: yv_w[k] is cell k output; index W is the zero injection.
    logic                 yv_w [W+1];
    logic signed [AW-1:0] yd_w [W+1];

    assign xv_w[0] = xin_q.v;
    assign xd_w[0] = xin_q.d;
    assign yv_w[W] = inject_w;
    assign yd_w[W] = '0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        if (k > 0) begin : g_link
            assign xv_w[k] = xo_v[k-1];
            assign xd_w[k] = xo_d[k-1];
        end
        bandmv_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .x_vld_i(xv_w[k]), .x_dat_i(xd_w[k]),
            .y_vld_i(yv_w[k+1]), .y_dat_i(yd_w[k+1]),
            .coef_i(coef_i[k*DW +: DW]),
            .x_vld_o(xo_v[k]), .x_dat_o(xo_d[k]),
            .y_vld_o(yv_w[k]), .y_dat_o(yd_w[k])
        );
    end

    logic unused_tail;
    assign unused_tail = ^{xo_v[W-1], xo_d[W-1]};

    assign y_valid_o = yv_w[0];
    assign y_data_o  = yd_w[0];

endmodule

// File: rtl/bandmv_chk.sv
module bandmv_chk #(
    parameter int CW   = 5,
    parameter int LAST = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy,
    input logic [CW-1:0] cnt,
    input logic          y_valid_o,
    input logic          done_o
);
    localparam logic [CW-1:0] CNT_STOP = CW'(LAST - 1);

    a_r3_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid_o |-> $past(busy));

    a_r3_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid_o |=> !y_valid_o);

    a_r4_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (y_valid_o && !busy));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && cnt != CNT_STOP) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

bind bandmv_top bandmv_chk #(.CW(CW), .LAST(LAST)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy_w), .cnt(cnt_w),
    .y_valid_o(y_valid_o), .done_o(done_o)
);

// File: tb/bandmv_top_test.sv
module bandmv_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int H  = 1;
    localparam int W  = 2 * H + 1;
    localparam int DW = 16;
    localparam int AW = 32;
    localparam int LAST = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic x_valid_i = 1'b0;
    logic signed [DW-1:0] x_data_i = '0;
    logic [W*DW-1:0] coef_i = '0;
    logic y_valid_o;
    logic signed [AW-1:0] y_data_o;
    logic done_o;

    int tests = 0;
    int fails = 0;
    int amat [1:N][1:N];
    int xv [1:N];

    always #(CLK_PERIOD/2) clk = ~clk;

    bandmv_top #(.N(N), .HALF_BW(H), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_valid_i(x_valid_i),
        .x_data_i(x_data_i), .coef_i(coef_i), .y_valid_o(y_valid_o),
        .y_data_o(y_data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0: mixed sign, 1: mostly negative, 2: extreme negative values
    task automatic fill_case(input int mode);
        for (int i = 1; i <= N; i++) begin
            xv[i] = (mode == 2) ? -32768 : (mode == 1) ? -(i * 301 + 7) : (i * 53 - 200);
            for (int j = 1; j <= N; j++) begin
                if (i - j > H || j - i > H) amat[i][j] = 0;
                else if (mode == 2) amat[i][j] = -32768;
                else if (mode == 1) amat[i][j] = -((i * 37 + j * 11) % 900) - 1;
                else amat[i][j] = ((i * 37 + j * 19) % 400) - 190;
            end
        end
    endtask

    task automatic run_case(input string req, input bit junk, input bit restart);
        int yexp [1:N];
        for (int i = 1; i <= N; i++) begin
            yexp[i] = 0;
            for (int j = 1; j <= N; j++) yexp[i] += amat[i][j] * xv[j];
        end
        @(posedge clk); #1;
        start_i = 1'b1; x_valid_i = 1'b1; x_data_i = DW'(xv[1]);
        coef_i = junk ? {W{16'h3c5a}} : '0;
        for (int t = 0; t <= LAST + 2; t++) begin
            @(posedge clk); #1;
            start_i = restart && (t == 4 || t == 9);
            // R8 coefficient schedule
            for (int k = 0; k < W; k++) begin
                int cv;
                cv = junk ? (t * 131 + k * 7 + 5) : 0;
                if ((t - k) % 2 == 0 && t - k >= 0 && t - 2 * H + k >= 0) begin
                    int jj, ii;
                    jj = (t - k) / 2 + 1;
                    ii = (t - 2 * H + k) / 2 + 1;
                    if (ii >= 1 && ii <= N && jj >= 1 && jj <= N) cv = amat[ii][jj];
                end
                coef_i[k*DW +: DW] = DW'(cv);
            end
            if (t % 2 == 1 && (t + 3) / 2 <= N) begin
                x_valid_i = 1'b1; x_data_i = DW'(xv[(t + 3) / 2]);
            end else begin
                x_valid_i = 1'b0; x_data_i = junk ? DW'(t * 977 + 13) : '0;
            end
            @(negedge clk);
            begin
                bit ev;
                int row;
                ev  = (t >= 2 * H + 1) && ((t - 2 * H - 1) % 2 == 0) && ((t - 2 * H - 1) / 2 < N);
                row = (t - 2 * H - 1) / 2 + 1;
                chk(y_valid_o == ev, "R3", $sformatf("valid t=%0d", t), y_valid_o, ev);
                if (ev && y_valid_o)
                    chk($signed(y_data_o) == yexp[row], req, $sformatf("row %0d", row),
                        $signed(y_data_o), yexp[row]);
                chk(done_o == (t == LAST), restart ? "R5" : "R4", $sformatf("done t=%0d", t),
                    done_o, (t == LAST));
            end
        end
        start_i = 1'b0; x_valid_i = 1'b0; x_data_i = '0; coef_i = '0;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!y_valid_o, "R1", "y_valid after reset", y_valid_o, 0);
        chk(!done_o, "R1", "done after reset", done_o, 0);
    endtask

    task automatic t_mixed;     fill_case(0); run_case("R2", 1'b0, 1'b0); endtask
    task automatic t_negative;  fill_case(1); run_case("R2", 1'b0, 1'b0); endtask
    task automatic t_wrap;      fill_case(2); run_case("R7", 1'b0, 1'b0); endtask
    task automatic t_junk;      fill_case(0); run_case("R6", 1'b1, 1'b0); endtask
    task automatic t_restart;   fill_case(1); run_case("R5", 1'b0, 1'b1); endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        repeat (2) @(posedge clk);
        t_reset();
        t_mixed();
        t_negative();
        t_wrap();
        t_junk();
        t_restart();
        t_mixed();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule